// File: doc/BRIEF.md
# Segmented Issue Queue with Staged Preselection

This block holds dispatched instructions until their operands are ready, then sends up to four of them per cycle to execution. Each instruction brings two source tags, a ready flag for each, and one destination tag. The 32 entries are split into four segments of eight. A wakeup tag enters segment one and then moves through a register into the next segment each cycle. Because of this, no single cycle has to drive a tag across the whole window.

Segments two, three and four each pick their oldest ready entries every cycle (at most 3, 2 and 2). The chosen entries go into seven staging registers. In the next cycle the issue selector takes the four oldest instructions from two groups: the ready entries of segment one, and the staged candidates. A staged candidate that loses stays in its entry and can be picked again later. An entry is freed only when it issues.

The tags that wake waiting entries come from two places: the destination tags of instructions issued in the current cycle, and one external result tag. New instructions are written into the lowest free entry. A full flag tells the dispatcher to hold. A clear input empties the window.

Top module: `seg_issue_window`

## Requirements
- R1: A dispatched instruction goes into the lowest-numbered free entry. Entries 0-7 form segment one, 8-15 segment two, 16-23 segment three and 24-31 segment four. `full` is high exactly when all 32 entries are occupied. A dispatch presented while `full` is high is dropped.
- R2: A ready instruction written into segment one at the end of cycle d issues in cycle d+1.
- R3: A ready instruction written into segments two to four at the end of cycle d is staged at the end of cycle d+1 and issues in cycle d+2.
- R4: At most four instructions issue per cycle, chosen oldest-first by dispatch order. Valid issue slots are contiguous from slot 0, and slot 0 holds the oldest.
- R5: Each cycle, segments two, three and four stage at most 3, 2 and 2 of their ready entries, oldest first. An entry that is currently staged is not picked again in that cycle.
- R6: A tag broadcast in cycle t (an issued destination tag, or `res_tag` with `res_valid`) lets a waiting entry issue at t+1 if the entry is in segment one, or at t+k+1 if it is in segment k (k = 2..4), provided nothing else competes.
- R7: An entry becomes eligible only when both of its sources are ready. A source can be ready from its dispatch flag or from a matching tag broadcast.
- R8: A staged candidate that the issue selector does not choose keeps its entry. It is staged again later and then issues. Segment-one entries and staged candidates compete purely by age.
- R9: After reset, and in the cycle after `flush`, the window is empty: nothing issues and `full` is low. The next dispatch lands in entry 0.
- R10: A dispatched source whose tag is broadcast to the target segment in the dispatch cycle is recorded as ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empties the window at the next edge |
| disp_valid | input | 1 | Dispatch request |
| disp_src1 | input | TAG_W | First source tag |
| disp_src1_rdy | input | 1 | First source already available |
| disp_src2 | input | TAG_W | Second source tag |
| disp_src2_rdy | input | 1 | Second source already available |
| disp_dst | input | TAG_W | Destination tag |
| full | output | 1 | All entries occupied; dispatch dropped |
| res_valid | input | 1 | External result tag valid |
| res_tag | input | TAG_W | External result tag |
| iss_valid | output | ISSUE_W | Issue slot valid, slot 0 oldest |
| iss_dst | output | ISSUE_W x TAG_W | Destination tag per issue slot |
| iss_seq | output | ISSUE_W x SEQ_W | Dispatch sequence number per slot |

## Verification
The assertions check, on every cycle, three properties of the issue slots: they are filled contiguously, they are in strict age order across slots, and every staged candidate points to an entry that is still occupied. The assertions also check that a full window stays full when nothing issues, and that a clear leaves nothing to issue in the following cycle.

Other behaviours can only be shown by the bench scenarios, because they depend on when an instruction issues relative to its dispatch or wakeup:
- latency that depends on the segment,
- the per-segment staging quotas,
- the reissue of a candidate that lost,
- capture of a tag at dispatch time.

The bench sweeps every entry position and every segment with blockers, and predicts each issue cycle from these timing rules.

// File: rtl/seg_issue_window.sv
module seg_issue_window #(
  parameter int TAG_W   = 6,
  parameter int SEQ_W   = 8,
  parameter int SEG_N   = 8,
  parameter int ISSUE_W = 4,
  parameter int Q2      = 3,
  parameter int Q3      = 2,
  parameter int Q4      = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            flush,
  input  logic                            disp_valid,
  input  logic [TAG_W-1:0]                disp_src1,
  input  logic                            disp_src1_rdy,
  input  logic [TAG_W-1:0]                disp_src2,
  input  logic                            disp_src2_rdy,
  input  logic [TAG_W-1:0]                disp_dst,
  output logic                            full,
  input  logic                            res_valid,
  input  logic [TAG_W-1:0]                res_tag,
  output logic [ISSUE_W-1:0]              iss_valid,
  output logic [ISSUE_W-1:0][TAG_W-1:0]   iss_dst,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]   iss_seq
);
  localparam int SEGS   = 4;
  localparam int ENT    = SEGS * SEG_N;
  localparam int IDX_W  = $clog2(ENT);
  localparam int LAT_N  = Q2 + Q3 + Q4;
  localparam int CAND_N = SEG_N + LAT_N;
  localparam int NBC    = ISSUE_W + 1;

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  function automatic int quota(input int s);
    return (s == 1) ? Q2 : ((s == 2) ? Q3 : Q4);
  endfunction

  function automatic int lbase(input int s);
    return (s == 1) ? 0 : ((s == 2) ? Q2 : Q2 + Q3);
  endfunction

  logic [ENT-1:0]   v, r1, r2, rdy, inlat, pc, issued, w1, w2;
  logic [TAG_W-1:0] s1t [ENT];
  logic [TAG_W-1:0] s2t [ENT];
  logic [TAG_W-1:0] dt  [ENT];
  logic [SEQ_W-1:0] sq  [ENT];
  logic [SEQ_W-1:0] seq_ctr;

  logic [LAT_N-1:0] lat_v, nlat_v;
  logic [IDX_W-1:0] lat_i  [LAT_N];
  logic [IDX_W-1:0] nlat_i [LAT_N];

  logic [NBC-1:0]                        b0v;
  logic [NBC-1:0][TAG_W-1:0]             b0t;
  logic [SEGS-2:0][NBC-1:0]              bpv;
  logic [SEGS-2:0][NBC-1:0][TAG_W-1:0]   bpt;
  logic [SEGS-1:0][NBC-1:0]              bv;
  logic [SEGS-1:0][NBC-1:0][TAG_W-1:0]   bt;

  logic [CAND_N-1:0] cv;
  logic [IDX_W-1:0]  ce [CAND_N];
  logic [IDX_W-1:0]  slot;
  logic              accept, d1hit, d2hit;

  assign b0v    = {res_valid, iss_valid};
  assign b0t    = {res_tag, iss_dst};
  assign bv     = {bpv, b0v};
  assign bt     = {bpt, b0t};
  assign rdy    = v & r1 & r2;
  assign pc     = rdy & ~inlat;
  assign full   = &v;
  assign accept = disp_valid & ~full;

  always_comb begin
    inlat = '0;
    for (int k = 0; k < LAT_N; k++)
      if (lat_v[k]) inlat[lat_i[k]] = 1'b1;
  end

  always_comb begin
    slot = '0;
    for (int e = ENT - 1; e >= 0; e--)
      if (!v[e]) slot = IDX_W'(e);
  end

  always_comb begin
    int ds;
    w1 = '0;
    w2 = '0;
    for (int e = 0; e < ENT; e++)
      for (int j = 0; j < NBC; j++) begin
        if (bv[e / SEG_N][j] && bt[e / SEG_N][j] == s1t[e]) w1[e] = 1'b1;
        if (bv[e / SEG_N][j] && bt[e / SEG_N][j] == s2t[e]) w2[e] = 1'b1;
      end
    ds = int'(slot) / SEG_N;
    d1hit = 1'b0;
    d2hit = 1'b0;
    for (int j = 0; j < NBC; j++) begin
      if (bv[ds][j] && bt[ds][j] == disp_src1) d1hit = 1'b1;
      if (bv[ds][j] && bt[ds][j] == disp_src2) d2hit = 1'b1;
    end
  end

  always_comb begin
    int n, e, f;
    nlat_v = '0;
    for (int k = 0; k < LAT_N; k++) nlat_i[k] = '0;
    for (int s = 1; s < SEGS; s++)
      for (int i = 0; i < SEG_N; i++) begin
        e = s * SEG_N + i;
        n = 0;
        for (int j = 0; j < SEG_N; j++) begin
          f = s * SEG_N + j;
          if (pc[f] && older(sq[f], sq[e])) n++;
        end
        if (pc[e] && n < quota(s)) begin
          nlat_v[lbase(s) + n] = 1'b1;
          nlat_i[lbase(s) + n] = IDX_W'(e);
        end
      end
  end

  always_comb begin
    int n;
    for (int c = 0; c < CAND_N; c++) begin
      if (c < SEG_N) begin
        cv[c] = rdy[c];
        ce[c] = IDX_W'(c);
      end else begin
        cv[c] = lat_v[c - SEG_N];
        ce[c] = lat_i[c - SEG_N];
      end
    end
    iss_valid = '0;
    iss_dst   = '0;
    iss_seq   = '0;
    issued    = '0;
    for (int c = 0; c < CAND_N; c++) begin
      n = 0;
      for (int c2 = 0; c2 < CAND_N; c2++)
        if (cv[c2] && older(sq[ce[c2]], sq[ce[c]])) n++;
      if (cv[c] && n < ISSUE_W) begin
        iss_valid[n]   = 1'b1;
        iss_dst[n]     = dt[ce[c]];
        iss_seq[n]     = sq[ce[c]];
        issued[ce[c]]  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v       <= '0;
      lat_v   <= '0;
      bpv     <= '0;
      seq_ctr <= '0;
    end else if (flush) begin
      v     <= '0;
      lat_v <= '0;
      bpv   <= '0;
    end else begin
      v     <= (v & ~issued) | (accept ? (ENT'(1) << slot) : '0);
      lat_v <= nlat_v;
      bpv   <= bv[SEGS-2:0];
      if (accept) seq_ctr <= seq_ctr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    r1    <= r1 | w1;
    r2    <= r2 | w2;
    lat_i <= nlat_i;
    bpt   <= bt[SEGS-2:0];
    if (accept) begin
      s1t[slot] <= disp_src1;
      s2t[slot] <= disp_src2;
      dt[slot]  <= disp_dst;
      sq[slot]  <= seq_ctr;
      r1[slot]  <= disp_src1_rdy | d1hit;
      r2[slot]  <= disp_src2_rdy | d2hit;
    end
  end

  generate
    for (genvar j = 1; j < ISSUE_W; j++) begin : g_slot_chk
      // R4
      slot_pack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[j] |-> iss_valid[j-1]);
      // R4
      age_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid[j] |-> older(iss_seq[j-1], iss_seq[j]));
    end
    for (genvar k = 0; k < LAT_N; k++) begin : g_lat_chk
      // R8
      latch_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lat_v[k] |-> v[lat_i[k]]);
    end
  endgenerate

  // R9
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (iss_valid == '0) && !full);

  // R1
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !flush && iss_valid == '0) |=> full);
endmodule

// File: tb/seg_issue_window_test.sv
`timescale 1ns/1ps
module seg_issue_window_test;
  localparam int TAG_W = 6, SEQ_W = 8, ISSUE_W = 4;

  logic clk = 0, rst_n = 0, flush = 0;
  logic disp_valid = 0, disp_src1_rdy = 0, disp_src2_rdy = 0;
  logic [TAG_W-1:0] disp_src1 = '0, disp_src2 = '0, disp_dst = '0;
  logic res_valid = 0;
  logic [TAG_W-1:0] res_tag = '0;
  logic full;
  logic [ISSUE_W-1:0] iss_valid;
  logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst;
  logic [ISSUE_W-1:0][SEQ_W-1:0] iss_seq;

  seg_issue_window uut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
    .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy), .disp_dst(disp_dst),
    .full(full), .res_valid(res_valid), .res_tag(res_tag),
    .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_seq(iss_seq)
  );

  always #2 clk = ~clk;

  int cyc = 0, nchk = 0, nerr = 0, last_d = 0, t = 0, t2 = 0;
  int iss_at [64];
  int iss_n  [64];
  int iss_sl [64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk)
    if (rst_n)
      for (int j = 0; j < ISSUE_W; j++)
        if (iss_valid[j]) begin
          iss_at[iss_dst[j]] = cyc;
          iss_sl[iss_dst[j]] = j;
          iss_n[iss_dst[j]]++;
        end

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_rec;
    for (int i = 0; i < 64; i++) begin
      iss_at[i] = -1;
      iss_n[i]  = 0;
      iss_sl[i] = -1;
    end
  endtask

  task automatic fresh;
    flush = 1;
    step;
    flush = 0;
    clear_rec;
  endtask

  task automatic disp(input int a, input bit ar, input int b, input bit br, input int d);
    disp_valid = 1; disp_src1 = TAG_W'(a); disp_src1_rdy = ar;
    disp_src2 = TAG_W'(b); disp_src2_rdy = br; disp_dst = TAG_W'(d);
    last_d = cyc;
    step;
    disp_valid = 0;
  endtask

  task automatic blockers(input int n);
    for (int i = 0; i < n; i++) disp(63, 0, 63, 0, 62);
  endtask

  task automatic wake(input int tg);
    res_valid = 1; res_tag = TAG_W'(tg);
    t = cyc;
    step;
    res_valid = 0;
  endtask

  initial begin
    clear_rec;
    idle(3);
    chk(full == 0, "R9 reset full", int'(full), 0);
    chk(iss_valid == 0, "R9 reset issue", int'(iss_valid), 0);
    rst_n = 1;
    step;

    // R1 R2 R3: every entry position, ready at dispatch
    for (int pos = 0; pos < 32; pos++) begin
      fresh;
      blockers(pos);
      disp(0, 1, 0, 1, 5);
      idle(4);
      chk(iss_at[5] == last_d + (pos < 8 ? 1 : 2) && iss_n[5] == 1,
          pos < 8 ? "R2 seg1 latency" : "R3 staged latency",
          iss_at[5] - last_d, pos < 8 ? 1 : 2);
    end

    // R1: full window drops dispatch
    fresh;
    blockers(32);
    chk(full == 1, "R1 full flag", int'(full), 1);
    for (int i = 0; i < 3; i++) disp(0, 1, 0, 1, 5);
    idle(4);
    chk(iss_n[5] == 0, "R1 dispatch while full", iss_n[5], 0);
    fresh;
    chk(full == 0, "R9 flush clears full", int'(full), 0);

    // R6: external wakeup per segment
    for (int k = 0; k < 4; k++) begin
      fresh;
      blockers(8 * k);
      disp(10, 0, 0, 1, 20);
      idle(2);
      wake(10);
      idle(8);
      chk(iss_at[20] == t + (k == 0 ? 1 : k + 2), "R6 wake latency", iss_at[20] - t,
          k == 0 ? 1 : k + 2);
    end

    // R4 R6: issue-broadcast wake and oldest-first order
    fresh;
    for (int i = 0; i < 7; i++) disp(30, 0, 0, 1, i);
    disp(0, 1, 0, 1, 30);
    idle(6);
    chk(iss_at[30] == last_d + 1, "R6 producer issue", iss_at[30] - last_d, 1);
    for (int i = 0; i < 7; i++) begin
      chk(iss_at[i] == last_d + 2 + i / 4, "R4 R6 consumer cycle", iss_at[i] - last_d, 2 + i / 4);
      chk(iss_sl[i] == i % 4, "R4 slot order", iss_sl[i], i % 4);
    end

    // R5: staging quotas per segment
    for (int k = 1; k < 4; k++) begin
      fresh;
      blockers(8 * k);
      for (int i = 0; i < 8; i++) disp(11, 0, 0, 1, i);
      wake(11);
      idle(12);
      for (int i = 0; i < 8; i++) begin
        chk(iss_at[i] == t + k + 2 + i / (k == 1 ? 3 : 2), "R5 quota cycle",
            iss_at[i] - t, k + 2 + i / (k == 1 ? 3 : 2));
        chk(iss_sl[i] == i % (k == 1 ? 3 : 2), "R5 quota slot", iss_sl[i], i % (k == 1 ? 3 : 2));
      end
    end

    // R8: losing staged candidates are reissued later
    fresh;
    for (int i = 0; i < 4; i++) disp(12, 0, 0, 1, i);
    blockers(4);
    for (int i = 4; i < 7; i++) disp(13, 0, 0, 1, i);
    wake(13);
    t2 = t;
    idle(1);
    wake(12);
    idle(8);
    for (int i = 0; i < 4; i++) begin
      chk(iss_at[i] == t2 + 3 && iss_sl[i] == i, "R8 seg1 wins", iss_at[i] - t2, 3);
    end
    for (int i = 4; i < 7; i++) begin
      chk(iss_at[i] == t2 + 5 && iss_n[i] == 1, "R8 reissue", iss_at[i] - t2, 5);
    end

    // R7: both sources required
    fresh;
    disp(14, 0, 15, 0, 7);
    wake(14);
    idle(3);
    chk(iss_n[7] == 0, "R7 one source only", iss_n[7], 0);
    wake(15);
    idle(3);
    chk(iss_at[7] == t + 1, "R7 both sources", iss_at[7] - t, 1);

    // R10: tag captured during dispatch, segment one
    fresh;
    disp_valid = 1; disp_src1 = 16; disp_src1_rdy = 0;
    disp_src2 = 0; disp_src2_rdy = 1; disp_dst = 8;
    res_valid = 1; res_tag = 16;
    last_d = cyc;
    step;
    disp_valid = 0; res_valid = 0;
    idle(3);
    chk(iss_at[8] == last_d + 1, "R10 capture seg1", iss_at[8] - last_d, 1);

    // R10: tag captured in segment two one cycle after broadcast
    fresh;
    blockers(8);
    wake(17);
    disp(17, 0, 0, 1, 9);
    idle(5);
    chk(iss_at[9] == t + 3, "R10 capture seg2", iss_at[9] - t, 3);

    // R9: flush with staged candidates in flight
    fresh;
    blockers(8);
    for (int i = 0; i < 3; i++) disp(18, 0, 0, 1, i);
    wake(18);
    idle(1);
    flush = 1;
    step;
    flush = 0;
    idle(6);
    for (int i = 0; i < 3; i++)
      chk(iss_n[i] == 0, "R9 flush drops staged", iss_n[i], 0);
    chk(full == 0, "R9 flush full", int'(full), 0);
    disp(0, 1, 0, 1, 3);
    idle(3);
    chk(iss_at[3] == last_d + 1, "R9 refill entry 0", iss_at[3] - last_d, 1);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule